// File: doc/BRIEF.md
# Pedestal-Corrected ADC Channel Readout

The block reads a bank of sixteen 11-bit ADC channel values one after another. It addresses each channel through an index output, takes that channel's data back in the same cycle, and returns a registered corrected word. The correction subtracts a per-channel 8-bit pedestal, which is zero-extended to 11 bits. Any result that is zero or below is clamped to zero and raises a zero flag. A separate overflow test on the raw data forces the full-scale code 2047.

The sixteen pedestals sit in a small store. A register-style host port writes them and reads them back by a 4-bit subaddress, but only while the block is idle. A mode input decides whether the stored pedestal reaches the subtractor or a zero is used in its place. A 4-bit mask over raw data bits 7 to 10 sets the overflow threshold to match the ADC resolution:

| Resolution | Mask | Threshold |
|---|---|---|
| 8-bit | `0010` | 256 |
| 9-bit | `0100` | 512 |
| 10-bit | `1000` | 1024 |
| 11-bit | `1111` | 1920 |

A one-cycle start pulse launches a scan. Sixteen valid beats follow on consecutive cycles, and a done pulse comes with the last beat.

Top module: `ped_readout`

## Requirements
- R1: After reset, out_valid_o, done_o, busy_o and host_rvalid_o are 0, and every pedestal entry reads back as 0.
- R2: A start_i pulse while idle produces exactly 16 beats on consecutive cycles, the first one cycle after start_i is sampled. out_chan_o runs 0 to 15, done_o is high only with beat 15, and a start_i while busy is ignored.
- R3: While idle, host_we_i stores host_wdata_i at host_addr_i. host_re_i returns that entry on host_rdata_o with host_rvalid_o high one cycle later.
- R4: While busy_o is high, host writes leave the store unchanged and host reads raise no host_rvalid_o.
- R5: With subtraction enabled, out_data_o equals the channel's ADC value minus its zero-extended 8-bit pedestal when that difference is positive and no overflow is detected.
- R6: With subtraction disabled, the pedestal is replaced by zero, so out_data_o equals the raw ADC value when no overflow is detected.
- R7: When the difference is zero or negative and no overflow is detected, out_data_o is 0 and out_zero_o is 1. Otherwise out_zero_o is 0.
- R8: Mask bit k (k = 0..3) selects raw data bit 7+k. Overflow occurs when the mask is non-zero and every selected bit is set; out_ovf_o is then 1 and out_data_o is 2047. A zero mask never gives overflow.
- R9: Overflow takes priority over the zero clamp: an overflowing channel shows 2047 with out_zero_o at 0, even if its difference is negative.
- R10: sub_en_i and ovf_mask_i are captured when a scan starts. Changes to them during the scan have no effect on that scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Scan launch pulse |
| sub_en_i | input | 1 | Pedestal subtraction enable |
| ovf_mask_i | input | 4 | Overflow bit select over raw bits 7..10 |
| busy_o | output | 1 | Scan in progress |
| rd_idx_o | output | 4 | Channel index presented to the ADC data source |
| adc_data_i | input | 11 | Raw data of the channel at rd_idx_o, same cycle |
| host_we_i | input | 1 | Pedestal write strobe |
| host_re_i | input | 1 | Pedestal read strobe |
| host_addr_i | input | 4 | Pedestal subaddress |
| host_wdata_i | input | 8 | Pedestal write value |
| host_rdata_o | output | 8 | Pedestal read value |
| host_rvalid_o | output | 1 | Read data valid |
| out_valid_o | output | 1 | Corrected beat valid |
| out_chan_o | output | 4 | Channel of the current beat |
| out_data_o | output | 11 | Corrected word |
| out_ovf_o | output | 1 | Overflow flag |
| out_zero_o | output | 1 | Zero clamp flag |
| done_o | output | 1 | Last beat of the scan |

## Verification
The assertions assume that adc_data_i answers rd_idx_o within the same cycle and that start_i arrives only as a pulse. They also assume that host strobes are single-cycle requests, so a beat's channel number and flags come from one consistent lookup. The stimulus serves ADC data from a bench-side table indexed by rd_idx_o. It drives every strobe for exactly one cycle, and it changes the mode and mask inputs mid-scan only in the scenario that checks their capture.

// File: rtl/ped_readout_pkg.sv
package ped_readout_pkg;
  localparam int ADC_W    = 11;
  localparam int PED_W    = 8;
  localparam int N_CH     = 16;
  localparam int IDX_W    = $clog2(N_CH);
  localparam int MASK_W   = 4;
  localparam int MASK_LSB = 7;
  localparam logic [ADC_W-1:0] FULL_SCALE = {ADC_W{1'b1}};

  typedef struct packed {
    logic             ovf;
    logic             zero;
    logic [ADC_W-1:0] data;
  } corr_t;
endpackage

// File: rtl/ped_store.sv
module ped_store
  import ped_readout_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ready_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] addr_i,
  input  logic [PED_W-1:0] wdata_i,
  output logic [PED_W-1:0] rdata_o,
  output logic             rvalid_o,
  input  logic [IDX_W-1:0] look_idx_i,
  output logic [PED_W-1:0] look_o
);
  logic [PED_W-1:0] ped_q [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ped_q[g] <= '0;
      else if (ready_i && we_i && addr_i == IDX_W'(g)) ped_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= ready_i && re_i;
      if (ready_i && re_i) rdata_o <= ped_q[addr_i];
    end
  end

  assign look_o = ped_q[look_idx_i];

  // R4
  rd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> !rvalid_o);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import ped_readout_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             launch_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  assign launch_o = start_i && !busy_o;
  assign last_o   = busy_o && idx_o == IDX_W'(N_CH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
    end else if (launch_o) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
    end else if (busy_o) begin
      idx_o <= idx_o + 1'b1;
      if (last_o) busy_o <= 1'b0;
    end
  end

  // R2
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o) |=> (busy_o && idx_o == $past(idx_o) + 1'b1));
endmodule

// File: rtl/corr_unit.sv
module corr_unit
  import ped_readout_pkg::*;
(
  input  logic [ADC_W-1:0]  adc_i,
  input  logic [PED_W-1:0]  ped_i,
  input  logic              sub_en_i,
  input  logic [MASK_W-1:0] mask_i,
  output corr_t             res_o
);
  logic [MASK_W-1:0] hit;
  logic              ovf;
  logic [ADC_W:0]    diff;
  logic [ADC_W-1:0]  ped_ext;

  for (genvar g = 0; g < MASK_W; g++) begin : g_sel
    assign hit[g] = !mask_i[g] || adc_i[MASK_LSB+g];
  end

  assign ovf     = (|mask_i) && (&hit);
  assign ped_ext = sub_en_i ? {{(ADC_W-PED_W){1'b0}}, ped_i} : '0;
  assign diff    = {1'b0, adc_i} - {1'b0, ped_ext};

  always_comb begin
    res_o = '0;
    if (ovf) begin
      res_o.ovf  = 1'b1;
      res_o.data = FULL_SCALE;
    end else if (diff[ADC_W] || diff[ADC_W-1:0] == '0) begin
      res_o.zero = 1'b1;
    end else begin
      res_o.data = diff[ADC_W-1:0];
    end
  end
endmodule

// File: rtl/ped_readout.sv
module ped_readout
  import ped_readout_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sub_en_i,
  input  logic [MASK_W-1:0] ovf_mask_i,
  output logic              busy_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [ADC_W-1:0]  adc_data_i,
  input  logic              host_we_i,
  input  logic              host_re_i,
  input  logic [IDX_W-1:0]  host_addr_i,
  input  logic [PED_W-1:0]  host_wdata_i,
  output logic [PED_W-1:0]  host_rdata_o,
  output logic              host_rvalid_o,
  output logic              out_valid_o,
  output logic [IDX_W-1:0]  out_chan_o,
  output logic [ADC_W-1:0]  out_data_o,
  output logic              out_ovf_o,
  output logic              out_zero_o,
  output logic              done_o
);
  logic              launch, last;
  logic [PED_W-1:0]  ped_cur;
  logic              sub_en_q;
  logic [MASK_W-1:0] mask_q;
  corr_t             res;

  seq_ctrl u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .launch_o (launch),
    .last_o   (last),
    .idx_o    (rd_idx_o)
  );

  ped_store u_ped (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ready_i    (!busy_o),
    .we_i       (host_we_i),
    .re_i       (host_re_i),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .rdata_o    (host_rdata_o),
    .rvalid_o   (host_rvalid_o),
    .look_idx_i (rd_idx_o),
    .look_o     (ped_cur)
  );

  corr_unit u_corr (
    .adc_i    (adc_data_i),
    .ped_i    (ped_cur),
    .sub_en_i (sub_en_q),
    .mask_i   (mask_q),
    .res_o    (res)
  );

  // scan configuration held for the whole scan
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_en_q <= 1'b0;
      mask_q   <= '0;
    end else if (launch) begin
      sub_en_q <= sub_en_i;
      mask_q   <= ovf_mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      done_o      <= 1'b0;
      out_chan_o  <= '0;
      out_data_o  <= '0;
      out_ovf_o   <= 1'b0;
      out_zero_o  <= 1'b0;
    end else begin
      out_valid_o <= busy_o;
      done_o      <= last;
      if (busy_o) begin
        out_chan_o <= rd_idx_o;
        out_data_o <= res.data;
        out_ovf_o  <= res.ovf;
        out_zero_o <= res.zero;
      end
    end
  end

  // R2
  chan_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !done_o) |=> (out_valid_o && out_chan_o == $past(out_chan_o) + 1'b1));
  // R2
  done_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (out_valid_o && out_chan_o == IDX_W'(N_CH - 1)));
  // R7
  zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_zero_o) |-> out_data_o == '0);
  // R8
  ovf_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ovf_o) |-> out_data_o == FULL_SCALE);
  // R9
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_ovf_o && out_zero_o));
endmodule

// File: tb/ped_readout_test.sv
`timescale 1ns/1ps
module ped_readout_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sub_en = 1'b0;
  logic [3:0]  mask = 4'd0;
  logic        busy;
  logic [3:0]  rd_idx;
  logic [10:0] adc_data;
  logic        we = 1'b0, re = 1'b0;
  logic [3:0]  haddr = 4'd0;
  logic [7:0]  hwdata = 8'd0, hrdata;
  logic        hrvalid, ovalid, oovf, ozero, odone;
  logic [3:0]  ochan;
  logic [10:0] odata;

  logic [10:0] adc_mem [16];
  logic [7:0]  ped_mdl [16];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  assign adc_data = adc_mem[rd_idx];

  ped_readout uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sub_en_i(sub_en),
    .ovf_mask_i(mask), .busy_o(busy), .rd_idx_o(rd_idx), .adc_data_i(adc_data),
    .host_we_i(we), .host_re_i(re), .host_addr_i(haddr), .host_wdata_i(hwdata),
    .host_rdata_o(hrdata), .host_rvalid_o(hrvalid), .out_valid_o(ovalid),
    .out_chan_o(ochan), .out_data_o(odata), .out_ovf_o(oovf), .out_zero_o(ozero),
    .done_o(odone)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] model(logic [10:0] a, logic [7:0] p, logic en, logic [3:0] m);
    int d;
    logic ov;
    ov = (m != 0) && ((a[10:7] & m) == m);
    if (ov) return {1'b1, 1'b0, 11'd2047};
    d = int'(a) - (en ? int'(p) : 0);
    if (d <= 0) return {1'b0, 1'b1, 11'd0};
    return {2'b00, 11'(d)};
  endfunction

  task automatic host_wr(logic [3:0] a, logic [7:0] v);
    @(negedge clk); we = 1'b1; haddr = a; hwdata = v;
    @(negedge clk); we = 1'b0;
    if (!busy) ped_mdl[a] = v;
  endtask

  task automatic host_rd(string req, logic [3:0] a);
    @(negedge clk); re = 1'b1; haddr = a;
    @(negedge clk); re = 1'b0;
    check(req, "rvalid", int'(hrvalid), 1);
    check(req, "rdata", int'(hrdata), int'(ped_mdl[a]));
  endtask

  // full scan; en/m are the values expected to be in force
  task automatic scan(string req, logic en, logic [3:0] m, bit twiddle);
    logic [12:0] e;
    @(negedge clk); start = 1'b1; sub_en = en; mask = m;
    @(negedge clk); start = 1'b0;
    if (twiddle) begin sub_en = ~en; mask = ~m; end
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      e = model(adc_mem[k], ped_mdl[k], en, m);
      check("R2", "valid", int'(ovalid), 1);
      check("R2", "chan", int'(ochan), k);
      check("R2", "done", int'(odone), int'(k == 15));
      check(req, "data", int'(odata), int'(e[10:0]));
      check(req, "zero", int'(ozero), int'(e[11]));
      check(req, "ovf", int'(oovf), int'(e[12]));
    end
    @(negedge clk);
    check("R2", "valid after scan", int'(ovalid), 0);
    sub_en = 1'b0; mask = 4'd0;
  endtask

  task automatic t_reset();
    check("R1", "valid", int'(ovalid), 0);
    check("R1", "done", int'(odone), 0);
    check("R1", "busy", int'(busy), 0);
    check("R1", "rvalid", int'(hrvalid), 0);
    for (int i = 0; i < 16; i++) ped_mdl[i] = 8'd0;
    host_rd("R1", 4'd0);
    host_rd("R1", 4'd15);
  endtask

  task automatic t_host();
    for (int i = 0; i < 16; i++) host_wr(4'(i), 8'(13 * i + 5));
    host_rd("R3", 4'd0);
    host_rd("R3", 4'd7);
    host_rd("R3", 4'd15);
    host_wr(4'd9, 8'hFF);
    host_rd("R3", 4'd9);
  endtask

  task automatic t_sub();
    for (int i = 0; i < 16; i++) adc_mem[i] = 11'(400 + 37 * i);
    scan("R5", 1'b1, 4'b1111, 1'b0);
  endtask

  task automatic t_nosub();
    scan("R6", 1'b0, 4'b1111, 1'b0);
  endtask

  task automatic t_clamp();
    for (int i = 0; i < 16; i++)
      adc_mem[i] = (i % 3 == 0) ? 11'(ped_mdl[i]) : (i % 3 == 1) ? 11'(ped_mdl[i] / 2) : 11'(ped_mdl[i] + 1);
    adc_mem[0] = 11'd0;
    scan("R7", 1'b1, 4'b1111, 1'b0);
    scan("R7", 1'b0, 4'b0000, 1'b0);
  endtask

  task automatic t_ovf();
    for (int i = 0; i < 16; i++) adc_mem[i] = 11'(128 * i + 100);
    adc_mem[15] = 11'd2047;
    scan("R8", 1'b1, 4'b0010, 1'b0);
    scan("R8", 1'b1, 4'b0100, 1'b0);
    scan("R8", 1'b1, 4'b1000, 1'b0);
    scan("R8", 1'b1, 4'b1111, 1'b0);
    scan("R8", 1'b1, 4'b0000, 1'b0);
  endtask

  task automatic t_prio();
    for (int i = 0; i < 16; i++) host_wr(4'(i), 8'd250);
    for (int i = 0; i < 16; i++) adc_mem[i] = (i % 2 == 0) ? 11'd128 : 11'd100;
    scan("R9", 1'b1, 4'b0001, 1'b0);
  endtask

  task automatic t_busy();
    logic [7:0] keep;
    keep = ped_mdl[3];
    @(negedge clk); start = 1'b1; sub_en = 1'b1; mask = 4'b1111;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check("R2", "chan busy scan", int'(ochan), k);
      check("R4", "rvalid while busy", int'(hrvalid), 0);
      we = (k == 3); re = (k == 3); haddr = 4'd3; hwdata = ~keep;
      start = (k == 6);
    end
    we = 1'b0; re = 1'b0; start = 1'b0;
    @(negedge clk);
    check("R2", "restart ignored", int'(ovalid), 0);
    check("R4", "rvalid after", int'(hrvalid), 0);
    host_rd("R4", 4'd3);
  endtask

  task automatic t_latch();
    for (int i = 0; i < 16; i++) adc_mem[i] = 11'(300 + 111 * i);
    scan("R10", 1'b1, 4'b1000, 1'b1);
    scan("R10", 1'b0, 4'b0100, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) adc_mem[i] = 11'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_host();
    t_sub();
    t_nosub();
    t_clamp();
    t_ovf();
    t_prio();
    t_busy();
    t_latch();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule